// File: doc/BRIEF.md
# Windowed Limit Monitor with Interrupt

This block watches a stream of conversion results from several analog input channels. Each result is 10 bits wide and arrives with a channel index on a valid/ready input. Each channel has two 8-bit thresholds: an upper one and a lower one. Because the thresholds are 8 bits against a 10-bit result, the comparison uses only the top eight result bits, so one threshold step equals four result codes. A result whose top byte is strictly above the upper threshold raises that channel's high flag. A result whose top byte is at or below the lower threshold raises that channel's low flag.

Flags are sticky. They are gathered in a status register that clears when it is read. An interrupt pin reports when any flag of a channel that is not masked is set. The pin works only while interrupts are enabled, and its polarity is set by a configuration bit.

Software reaches the thresholds, the mask, the configuration and the status through a plain register port. The port uses a single address with separate read and write strobes. Read data appears one cycle after the read strobe.

The result input never applies back-pressure: `cv_ready` is held high. A result is taken on every clock edge where `cv_valid` is high. A sender may therefore treat each valid cycle as accepted and need not hold data across cycles.

Top module: `vlim_window_irq`

## Requirements
- R1: After reset every upper threshold reads FFh and every lower threshold reads 00h. Status, mask and configuration read 00h. With configuration 00h the interrupt pin is at 1, its inactive level.
- R2: On a cycle with `cv_valid` high, if `cv_data[9:2]` is strictly greater than the upper threshold of channel `cv_ch`, status bit `cv_ch` is set on that clock edge.
- R3: On a cycle with `cv_valid` high, if `cv_data[9:2]` is less than or equal to the lower threshold of channel `cv_ch`, status bit `4+cv_ch` is set on that clock edge. This uses the default of 4 channels, so the low flags occupy bits 7:4.
- R4: No status bit is set in any cycle where `cv_valid` is low, whatever `cv_ch` and `cv_data` hold.
- R5: Status bits stay set until the status register (address 0) is read. That read returns the value held before the read and then clears it. A flag raised by a result in the same cycle as the read survives the clear.
- R6: The configuration register is at address 2. Bit 0 enables interrupts and bit 1 selects an active-high pin (1) or an active-low pin (0). The pin is active exactly when interrupts are enabled and some unmasked channel has a flag set.
- R7: The mask register is at address 1, with bit c for channel c. A mask bit of 1 stops both flags of that channel from activating the pin, while the flags are still recorded in status.
- R8: The thresholds are read/write at consecutive addresses. The upper threshold of channel c is at 4+2c and the lower threshold is at 5+2c. A write to the status address is ignored.
- R9: `reg_rdata` is loaded on the clock edge that samples `reg_rd` high. Unmapped addresses read as 00h.
- R10: `cv_ready` is high at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cv_valid | input | 1 | Conversion result valid |
| cv_ready | output | 1 | Always high; the block never stalls the result stream |
| cv_ch | input | 2 | Channel index of the result |
| cv_data | input | 10 | Conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt pin, polarity set by configuration bit 1 |

## Verification
A status read and a new threshold crossing can fall in the same cycle. In that case the clear caused by the read competes with the flag set by the result. The bench provokes this by driving a crossing result on a second channel on exactly the clock edge that samples a status read. The read must return only the flag that was already held. A second read must then show only the newly raised flag, proving the crossing was neither lost nor reported twice. The interrupt pin is also judged in that overlap, since it follows status with no added delay.

// File: rtl/vlim_pkg.sv
package vlim_pkg;
  // Register addresses; thresholds are interleaved upper/lower per channel.
  localparam int unsigned A_STATUS   = 0;
  localparam int unsigned A_MASK     = 1;
  localparam int unsigned A_CTRL     = 2;
  localparam int unsigned A_LIM_BASE = 4;

  typedef struct packed {
    logic act_high;  // bit 1: pin polarity
    logic irq_en;    // bit 0: interrupt enable
  } vlim_ctrl_t;

  function automatic int unsigned hi_addr(input int unsigned ch);
    return A_LIM_BASE + 2 * ch;
  endfunction

  function automatic int unsigned lo_addr(input int unsigned ch);
    return A_LIM_BASE + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/vlim_reg_bank.sv
module vlim_reg_bank
  import vlim_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NCH-1:0][LIM_W-1:0]   hi_lim,
  output logic [NCH-1:0][LIM_W-1:0]   lo_lim,
  output logic [NCH-1:0]              mask,
  output vlim_ctrl_t                  cfg
);

  for (genvar c = 0; c < NCH; c++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_lim[c] <= '1;
        lo_lim[c] <= '0;
      end else if (wr) begin
        if (addr == ADDR_W'(hi_addr(c))) hi_lim[c] <= wdata[LIM_W-1:0];
        if (addr == ADDR_W'(lo_addr(c))) lo_lim[c] <= wdata[LIM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      cfg  <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_MASK)) mask <= wdata[NCH-1:0];
      if (addr == ADDR_W'(A_CTRL)) cfg  <= vlim_ctrl_t'(wdata[1:0]);
    end
  end

endmodule

// File: rtl/vlim_window_cmp.sv
module vlim_window_cmp #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned RES_W = 10,
  parameter int unsigned LIM_W = 8,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned SHIFT = RES_W - LIM_W
) (
  input  logic                      cv_valid,
  input  logic [CH_W-1:0]           cv_ch,
  input  logic [RES_W-1:0]          cv_data,
  input  logic [NCH-1:0][LIM_W-1:0] hi_lim,
  input  logic [NCH-1:0][LIM_W-1:0] lo_lim,
  output logic [NCH-1:0]            hit_hi,
  output logic [NCH-1:0]            hit_lo
);

  // Extending a threshold with all-ones low bits gives the largest result
  // code sharing its top byte: above it means top byte strictly greater,
  // at or below it means top byte less than or equal.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel       = cv_valid && (cv_ch == CH_W'(c));
    assign hit_hi[c] = sel && (cv_data >  {hi_lim[c], {SHIFT{1'b1}}});
    assign hit_lo[c] = sel && (cv_data <= {lo_lim[c], {SHIFT{1'b1}}});
  end

endmodule

// File: rtl/vlim_irq_gen.sv
module vlim_irq_gen
  import vlim_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned ST_W = 2 * NCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  hit_hi,
  input  logic [NCH-1:0]  hit_lo,
  input  logic            clr,
  input  logic [NCH-1:0]  mask,
  input  vlim_ctrl_t      cfg,
  output logic [ST_W-1:0] status_q,
  output logic            irq_o
);

  logic [ST_W-1:0] hits;
  logic [NCH-1:0]  chan_flag;
  logic            pending;

  assign hits = {hit_lo, hit_hi};

  // A read clears what it returned; hits of the same cycle still land.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (clr) status_q <= hits;
    else          status_q <= status_q | hits;
  end

  assign chan_flag = status_q[NCH-1:0] | status_q[ST_W-1:NCH];
  assign pending   = cfg.irq_en && |(chan_flag & ~mask);
  assign irq_o     = cfg.act_high ? pending : ~pending;

endmodule

// File: rtl/vlim_window_irq.sv
module vlim_window_irq
  import vlim_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned ST_W  = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_valid,
  output logic              cv_ready,
  input  logic [CH_W-1:0]   cv_ch,
  input  logic [RES_W-1:0]  cv_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  logic [NCH-1:0][LIM_W-1:0] hi_lim;
  logic [NCH-1:0][LIM_W-1:0] lo_lim;
  logic [NCH-1:0]            mask;
  vlim_ctrl_t                cfg;
  logic [NCH-1:0]            hit_hi;
  logic [NCH-1:0]            hit_lo;
  logic [ST_W-1:0]           status_q;
  logic                      stat_rd;
  logic [DATA_W-1:0]         rd_mux;

  assign cv_ready = 1'b1;
  assign stat_rd  = reg_rd && (reg_addr == ADDR_W'(A_STATUS));

  vlim_reg_bank #(
    .NCH(NCH), .LIM_W(LIM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .hi_lim(hi_lim), .lo_lim(lo_lim),
    .mask(mask), .cfg(cfg)
  );

  vlim_window_cmp #(
    .NCH(NCH), .RES_W(RES_W), .LIM_W(LIM_W)
  ) u_cmp (
    .cv_valid(cv_valid && cv_ready), .cv_ch(cv_ch), .cv_data(cv_data),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .hit_hi(hit_hi), .hit_lo(hit_lo)
  );

  vlim_irq_gen #(
    .NCH(NCH)
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .hit_hi(hit_hi), .hit_lo(hit_lo),
    .clr(stat_rd), .mask(mask), .cfg(cfg),
    .status_q(status_q), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_STATUS)) rd_mux = DATA_W'(status_q);
    if (reg_addr == ADDR_W'(A_MASK))   rd_mux = DATA_W'(mask);
    if (reg_addr == ADDR_W'(A_CTRL))   rd_mux = DATA_W'(cfg);
    for (int unsigned c = 0; c < NCH; c++) begin
      if (reg_addr == ADDR_W'(hi_addr(c))) rd_mux = DATA_W'(hi_lim[c]);
      if (reg_addr == ADDR_W'(lo_addr(c))) rd_mux = DATA_W'(lo_lim[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/vlim_window_irq_chk.sv
module vlim_window_irq_chk
  import vlim_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned ST_W  = 2 * NCH,
  localparam int unsigned SHIFT = RES_W - LIM_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cv_valid,
  input logic [CH_W-1:0]           cv_ch,
  input logic [RES_W-1:0]          cv_data,
  input logic                      reg_rd,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic                      irq_o,
  input logic [ST_W-1:0]           status_q,
  input logic [NCH-1:0][LIM_W-1:0] hi_lim,
  input logic [NCH-1:0][LIM_W-1:0] lo_lim,
  input logic                      act_high
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_HI_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cv_valid) &&
    (($past(cv_data) >> SHIFT) > RES_W'($past(hi_lim[cv_ch])))
    |-> status_q[$past(cv_ch)]);  // R2

  AST_LO_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cv_valid) &&
    (($past(cv_data) >> SHIFT) <= RES_W'($past(lo_lim[cv_ch])))
    |-> status_q[NCH + $past(cv_ch)]);  // R3

  AST_NO_SPONTANEOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(cv_valid) |-> (status_q & ~$past(status_q)) == '0);  // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(reg_rd && reg_addr == ADDR_W'(A_STATUS))
    |-> ($past(status_q) & ~status_q) == '0);  // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(reg_rd && reg_addr == ADDR_W'(A_STATUS) && !cv_valid)
    |-> status_q == '0);  // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    status_q == '0 |-> irq_o == !act_high);  // R6

endmodule

bind vlim_window_irq vlim_window_irq_chk #(
  .NCH(NCH), .RES_W(RES_W), .LIM_W(LIM_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_ch(cv_ch),
  .cv_data(cv_data), .reg_rd(reg_rd), .reg_addr(reg_addr), .irq_o(irq_o),
  .status_q(status_q), .hi_lim(hi_lim), .lo_lim(lo_lim),
  .act_high(cfg.act_high)
);

// File: tb/vlim_window_irq_bench.sv
module vlim_window_irq_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv_valid = 1'b0;
  logic       cv_ready;
  logic [1:0] cv_ch = '0;
  logic [9:0] cv_data = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  vlim_window_irq u_vlim_window_irq (
    .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_ready(cv_ready),
    .cv_ch(cv_ch), .cv_data(cv_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  // One result, no read: the flag is in status after the next edge.
  task automatic push(input int ch, input int code);
    @(negedge clk); cv_valid = 1'b1; cv_ch = 2'(ch); cv_data = 10'(code);
    @(negedge clk); cv_valid = 1'b0;
  endtask

  logic [7:0] hi_tab [4];
  logic [7:0] lo_tab [4];

  initial begin
    logic [7:0] d;
    hi_tab = '{8'h80, 8'h10, 8'hFF, 8'h00};
    lo_tab = '{8'h40, 8'hF0, 8'h00, 8'h00};
    chk("R10 ready in reset", cv_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    chk("R1 irq idle", irq_o, 1);
    for (int c = 0; c < 4; c++) begin
      rd(4'(4 + 2 * c), d); chk("R1 upper default", d, 8'hFF);
      rd(4'(5 + 2 * c), d); chk("R1 lower default", d, 8'h00);
    end
    rd(4'd0, d); chk("R1 status", d, 0);
    rd(4'd1, d); chk("R1 mask", d, 0);
    rd(4'd2, d); chk("R1 ctrl", d, 0);

    // Map and readback
    for (int c = 0; c < 4; c++) begin
      wr(4'(4 + 2 * c), hi_tab[c]);
      wr(4'(5 + 2 * c), lo_tab[c]);
    end
    for (int c = 0; c < 4; c++) begin
      rd(4'(4 + 2 * c), d); chk("R8 upper readback", d, hi_tab[c]);
      rd(4'(5 + 2 * c), d); chk("R8 lower readback", d, lo_tab[c]);
    end
    wr(4'd2, 8'h03);
    rd(4'd2, d); chk("R6 ctrl readback", d, 8'h03);
    rd(4'd3, d);  chk("R9 unmapped 3", d, 0);
    rd(4'd15, d); chk("R9 unmapped 15", d, 0);

    // Exhaustive sweep: every channel, every result code
    for (int c = 0; c < 4; c++) begin
      for (int code = 0; code < 1024; code++) begin
        logic eh, el;
        logic [7:0] exp_st;
        eh = (code >> 2) > int'(hi_tab[c]);
        el = (code >> 2) <= int'(lo_tab[c]);
        exp_st = 8'((int'(eh) << c) | (int'(el) << (4 + c)));
        @(negedge clk); cv_valid = 1'b1; cv_ch = 2'(c); cv_data = 10'(code);
        @(negedge clk); cv_valid = 1'b0;
        chk("R6 irq after result", irq_o, eh | el);
        reg_rd = 1'b1; reg_addr = 4'd0;
        @(negedge clk); reg_rd = 1'b0;
        chk("R2 R3 status after result", reg_rdata, exp_st);
      end
    end
    chk("R10 ready during run", cv_ready, 1);
    chk("R5 cleared after sweep", irq_o, 0);

    // Read and new crossing in the same cycle
    push(0, 10'h3FC);
    @(negedge clk); cv_valid = 1'b1; cv_ch = 2'd1; cv_data = 10'd0;
    reg_rd = 1'b1; reg_addr = 4'd0;
    @(negedge clk); cv_valid = 1'b0; reg_rd = 1'b0;
    chk("R5 read returns held value", reg_rdata, 8'h01);
    chk("R5 irq follows surviving flag", irq_o, 1);
    rd(4'd0, d); chk("R5 same-cycle flag survives", d, 8'h20);
    rd(4'd0, d); chk("R5 cleared", d, 0);

    // Mask
    wr(4'd1, 8'h01);
    push(0, 10'h3FC);
    chk("R7 masked channel quiet", irq_o, 0);
    push(1, 10'd0);
    chk("R7 unmasked channel fires", irq_o, 1);
    wr(4'd1, 8'h0F);
    chk("R7 all masked", irq_o, 0);
    wr(4'd1, 8'h00);
    rd(4'd1, d); chk("R7 mask readback", d, 0);

    // Polarity and enable with flags held
    wr(4'd2, 8'h01); chk("R6 active low asserted", irq_o, 0);
    wr(4'd2, 8'h00); chk("R6 disabled active low idle", irq_o, 1);
    wr(4'd2, 8'h02); chk("R6 disabled active high idle", irq_o, 0);
    wr(4'd2, 8'h03); chk("R6 active high asserted", irq_o, 1);
    rd(4'd0, d); chk("R5 masked flags recorded", d, 8'h21);
    chk("R6 irq drops after clear", irq_o, 0);

    // No strobe, crossing value present
    @(negedge clk); cv_valid = 1'b0; cv_ch = 2'd0; cv_data = 10'h3FF;
    repeat (3) @(negedge clk);
    chk("R4 no strobe irq", irq_o, 0);
    rd(4'd0, d); chk("R4 no strobe status", d, 0);

    // Status write ignored
    push(0, 10'h3FC);
    wr(4'd0, 8'h00);
    chk("R8 status write leaves irq", irq_o, 1);
    rd(4'd0, d); chk("R8 status write ignored", d, 8'h01);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

endmodule